// File: doc/BRIEF.md
# Supply fault interrupt and recorder

This block gathers the comparator status of four supply channels and turns selected fault conditions into one latched, active-low interrupt. Each channel reports five conditions: bus-side over-voltage, bus-side under-voltage, a first and a second card-side under-voltage level, and over-current. Each of these twenty sources has its own enable bit. When an enabled source is active, the interrupt latches low. It stays low until a dedicated active-low clear input is pulled low, or until reset.

The block also keeps three sticky 8-bit fault registers. Whenever a qualifying interrupt event occurs, every monitor that is out of limits at that moment is ORed into these registers. This includes per-channel tracking-error flags, which are recorded but are not interrupt sources here. Software clears a fault bit only by writing a zero to it. Writing a one leaves the bit unchanged.

After the power-on request rises, a programmable holdoff suppresses both interrupts and recording. Nothing is raised or recorded while the request is low. The enable masks and the holdoff select share a small write port with the fault registers.

Top module: `supply_irq_recorder`

## Requirements
- R1: After reset irq_no is 1, all three fault registers read 0x00, both source-enable bytes read 0xFF and the holdoff byte reads 0x7F (1600 ms holdoff, all over-current sources enabled).
- R2: Write-port addresses are as follows. 0 is the enable byte for supplies 1/2, 1 is the enable byte for supplies 3/4, 2 is the holdoff byte, and 4, 5 and 6 are fault registers bus, card and misc. In each enable byte, bits [7:4] serve the odd supply and bits [3:0] the even supply, each nibble ordered OV, UV, card UV1, card UV2 from high bit to low. In the holdoff byte, bits [3:0] enable over-current of supplies 1..4, with bit 3 for supply 1. A source whose enable is 0 neither asserts the interrupt nor triggers a recording.
- R3: While armed, an enabled active source drives irq_no low one clock later. irq_no stays low, even after the source goes inactive, until the clear input is taken low.
- R4: clr_ni low at a clock edge forces irq_no to 1 after that edge, and it overrides any active source in the same cycle.
- R5: Holdoff byte bits [6:4] set the holdoff. 100, 101, 110 and 111 give 1, 2, 4 and 8 units of UNIT_CYC clocks, measured from the edge that first samples the power-on request high. With N holdoff clocks, a source held active from that edge lowers irq_no only after edge N+1.
- R6: Holdoff bits [6:4] of the form 0xx select no holdoff, so irq_no can fall after the second edge that samples the power-on request high.
- R7: At each interrupt event, the block ORs in the raw state of all monitors, whether enabled or not. The bus register takes UV in bits [7:4] and OV in bits [3:0]. The card register takes UV1 in bits [7:4] and UV2 in bits [3:0]. The misc register takes tracking error in bits [7:4] and over-current in bits [3:0]. In each nibble, supply 1 sits in the highest bit.
- R8: While pwr_on_i is 0, irq_no is not driven low and no fault bit is set.
- R9: A write to a fault register ANDs it with the written data: a 0 clears a bit and a 1 has no effect.
- R10: When a recording and a write to the same fault register fall in one cycle, the recorded bits are set after the write mask is applied.
- R11: During the holdoff the fault registers record nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset (power cycle) |
| pwr_on_i | input | 1 | Power-on request, active high |
| clr_ni | input | 1 | Interrupt clear, active low |
| bus_ov_i | input | 4 | Bus-side over-voltage per supply (bit 0 = supply 1) |
| bus_uv_i | input | 4 | Bus-side under-voltage per supply |
| card_uv1_i | input | 4 | Card-side first under-voltage level per supply |
| card_uv2_i | input | 4 | Card-side second under-voltage level per supply |
| ovc_i | input | 4 | Over-current per supply |
| trk_err_i | input | 4 | Tracking error per supply (recorded only) |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 8 | Register write data |
| irq_no | output | 1 | Latched interrupt, active low |
| flt_bus_o | output | 8 | Bus-side fault record |
| flt_card_o | output | 8 | Card-side fault record |
| flt_misc_o | output | 8 | Tracking and over-current fault record |

## Verification
The bench probes the exact holdoff boundary for every select code, one edge before and one edge at the release. An off-by-one counter, or a decoder that mixes up the 0xx codes, would raise the interrupt early or late there. It checks that a clear held low beats a still-active source and that the source re-fires once the clear lifts. A latch that prioritised the set, or a level-style output, would fail there. It drives disabled sources at known bit positions of each enable byte, records unmasked monitors alongside a masked trigger, writes ones and zeros to the fault registers, including in the same cycle as a recording, and lowers the power-on request with faults present. A design that ignored the mask, recorded only enabled causes, let writes set bits, or recorded during power-down would show the wrong register values.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  localparam int unsigned N_SUP = 4;
  localparam int unsigned DW    = 8;
  localparam int unsigned AW    = 3;

  localparam logic [AW-1:0] ADDR_EN12  = 3'd0;
  localparam logic [AW-1:0] ADDR_EN34  = 3'd1;
  localparam logic [AW-1:0] ADDR_HOLD  = 3'd2;
  localparam logic [AW-1:0] ADDR_FLT0  = 3'd4;

  localparam logic [DW-1:0] EN_RST   = 8'hFF;
  localparam logic [DW-1:0] HOLD_RST = 8'h7F;

  // supply 1 goes to the highest bit of a nibble
  function automatic logic [N_SUP-1:0] rev4(input logic [N_SUP-1:0] v);
    for (int i = 0; i < N_SUP; i++) rev4[i] = v[N_SUP-1-i];
  endfunction
endpackage

// File: rtl/sfr_holdoff.sv
module sfr_holdoff #(
  parameter int unsigned UNIT_CYC = 2000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pwr_on_i,
  input  logic [2:0] sel_i,
  output logic       armed_o
);
  localparam int unsigned MAX_CYC = 8 * UNIT_CYC;
  localparam int unsigned CW      = $clog2(MAX_CYC + 1);

  logic          pwr_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] len;

  always_comb len = sel_i[2] ? (CW'(UNIT_CYC) << sel_i[1:0]) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwr_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      pwr_q <= pwr_on_i;
      if (pwr_on_i && !pwr_q)  cnt_q <= len;
      else if (cnt_q != '0)    cnt_q <= cnt_q - CW'(1);
    end
  end

  assign armed_o = pwr_on_i & pwr_q & (cnt_q == '0);
endmodule

// File: rtl/sfr_sources.sv
module sfr_sources
  import sfr_pkg::*;
(
  input  logic [N_SUP-1:0] bus_ov_i,
  input  logic [N_SUP-1:0] bus_uv_i,
  input  logic [N_SUP-1:0] card_uv1_i,
  input  logic [N_SUP-1:0] card_uv2_i,
  input  logic [N_SUP-1:0] ovc_i,
  input  logic [N_SUP-1:0] trk_err_i,
  input  logic [DW-1:0]    en12_i,
  input  logic [DW-1:0]    en34_i,
  input  logic [N_SUP-1:0] oc_en_i,
  output logic             hit_o,
  output logic [DW-1:0]    snap_bus_o,
  output logic [DW-1:0]    snap_card_o,
  output logic [DW-1:0]    snap_misc_o
);
  logic [N_SUP-1:0] sup_hit;

  for (genvar s = 0; s < N_SUP; s++) begin : g_sup
    localparam int B = (s % 2 == 0) ? 4 : 0;
    logic [DW-1:0] eb;
    assign eb = (s < 2) ? en12_i : en34_i;
    assign sup_hit[s] = (bus_ov_i[s]   & eb[B+3])
                      | (bus_uv_i[s]   & eb[B+2])
                      | (card_uv1_i[s] & eb[B+1])
                      | (card_uv2_i[s] & eb[B])
                      | (ovc_i[s]      & oc_en_i[N_SUP-1-s]);
  end

  assign hit_o       = |sup_hit;
  assign snap_bus_o  = {rev4(bus_uv_i),   rev4(bus_ov_i)};
  assign snap_card_o = {rev4(card_uv1_i), rev4(card_uv2_i)};
  assign snap_misc_o = {rev4(trk_err_i),  rev4(ovc_i)};
endmodule

// File: rtl/sfr_fault_reg.sv
module sfr_fault_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         rec_i,
  input  logic [W-1:0] snap_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] keep, set;

  assign keep = wr_i  ? wdata_i : '1;
  assign set  = rec_i ? snap_i  : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= (q_o & keep) | set;  // record wins over clear
  end
endmodule

// File: rtl/supply_irq_recorder.sv
module supply_irq_recorder
  import sfr_pkg::*;
#(
  parameter int unsigned UNIT_CYC = 2000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pwr_on_i,
  input  logic             clr_ni,
  input  logic [N_SUP-1:0] bus_ov_i,
  input  logic [N_SUP-1:0] bus_uv_i,
  input  logic [N_SUP-1:0] card_uv1_i,
  input  logic [N_SUP-1:0] card_uv2_i,
  input  logic [N_SUP-1:0] ovc_i,
  input  logic [N_SUP-1:0] trk_err_i,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [DW-1:0]    wr_data_i,
  output logic             irq_no,
  output logic [DW-1:0]    flt_bus_o,
  output logic [DW-1:0]    flt_card_o,
  output logic [DW-1:0]    flt_misc_o
);
  localparam int unsigned N_FLT = 3;

  logic [DW-1:0] en12_q, en34_q, hold_q;
  logic          armed, hit, fire, irq_q;
  logic [N_FLT-1:0][DW-1:0] snap, flt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en12_q <= EN_RST;
      en34_q <= EN_RST;
      hold_q <= HOLD_RST;
    end else if (wr_en_i) begin
      if (wr_addr_i == ADDR_EN12) en12_q <= wr_data_i;
      if (wr_addr_i == ADDR_EN34) en34_q <= wr_data_i;
      if (wr_addr_i == ADDR_HOLD) hold_q <= wr_data_i;
    end
  end

  sfr_holdoff #(.UNIT_CYC(UNIT_CYC)) u_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pwr_on_i (pwr_on_i),
    .sel_i    (hold_q[6:4]),
    .armed_o  (armed)
  );

  sfr_sources u_src (
    .bus_ov_i    (bus_ov_i),
    .bus_uv_i    (bus_uv_i),
    .card_uv1_i  (card_uv1_i),
    .card_uv2_i  (card_uv2_i),
    .ovc_i       (ovc_i),
    .trk_err_i   (trk_err_i),
    .en12_i      (en12_q),
    .en34_i      (en34_q),
    .oc_en_i     (hold_q[3:0]),
    .hit_o       (hit),
    .snap_bus_o  (snap[0]),
    .snap_card_o (snap[1]),
    .snap_misc_o (snap[2])
  );

  assign fire = armed & hit;

  for (genvar g = 0; g < N_FLT; g++) begin : g_flt
    sfr_fault_reg #(.W(DW)) u_reg (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .rec_i   (fire),
      .snap_i  (snap[g]),
      .wr_i    (wr_en_i && (wr_addr_i == AW'(ADDR_FLT0 + g))),
      .wdata_i (wr_data_i),
      .q_o     (flt[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      irq_q <= 1'b0;
    else if (!clr_ni) irq_q <= 1'b0;
    else if (fire)    irq_q <= 1'b1;
  end

  assign irq_no     = ~irq_q;
  assign flt_bus_o  = flt[0];
  assign flt_card_o = flt[1];
  assign flt_misc_o = flt[2];
endmodule

// File: rtl/sfr_checker.sv
module sfr_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       pwr_on_i,
  input logic       clr_ni,
  input logic       wr_en_i,
  input logic [2:0] wr_addr_i,
  input logic [7:0] wr_data_i,
  input logic       irq_no,
  input logic [7:0] flt_bus_o,
  input logic [7:0] flt_card_o,
  input logic [7:0] flt_misc_o
);
  a_r4_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_ni |=> irq_no);

  a_r3_latch_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_no && clr_ni) |=> !irq_no);

  a_r8_no_fire_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pwr_on_i && irq_no) |=> irq_no);

  a_r8_no_record_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pwr_on_i && !wr_en_i) |=> ($stable(flt_bus_o) && $stable(flt_card_o) && $stable(flt_misc_o)));

  a_r9_no_decay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> (((flt_bus_o & $past(flt_bus_o)) == $past(flt_bus_o)) &&
                  ((flt_card_o & $past(flt_card_o)) == $past(flt_card_o)) &&
                  ((flt_misc_o & $past(flt_misc_o)) == $past(flt_misc_o))));

  a_r9_write_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == 3'd4 && !pwr_on_i) |=> (flt_bus_o == ($past(flt_bus_o) & $past(wr_data_i))));
endmodule

bind supply_irq_recorder sfr_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pwr_on_i   (pwr_on_i),
  .clr_ni     (clr_ni),
  .wr_en_i    (wr_en_i),
  .wr_addr_i  (wr_addr_i),
  .wr_data_i  (wr_data_i),
  .irq_no     (irq_no),
  .flt_bus_o  (flt_bus_o),
  .flt_card_o (flt_card_o),
  .flt_misc_o (flt_misc_o)
);

// File: tb/sim_supply_irq_recorder.sv
`timescale 1ns/1ps
module sim_supply_irq_recorder;
  localparam int unsigned UNIT = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwr_on = 1'b0, clr_n = 1'b1;
  logic [3:0] ov = '0, uv = '0, cuv1 = '0, cuv2 = '0, oc = '0, trk = '0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       irq_n;
  logic [7:0] f_bus, f_card, f_misc;

  int nchk = 0, nerr = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  supply_irq_recorder #(.UNIT_CYC(UNIT)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .pwr_on_i(pwr_on), .clr_ni(clr_n),
    .bus_ov_i(ov), .bus_uv_i(uv), .card_uv1_i(cuv1), .card_uv2_i(cuv2),
    .ovc_i(oc), .trk_err_i(trk),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .irq_no(irq_n), .flt_bus_o(f_bus), .flt_card_o(f_card), .flt_misc_o(f_misc)
  );

  // sel: 0 irq_no, 1 bus, 2 card, 3 misc
  typedef struct { string req; int sel; logic [7:0] val; } exp_t;
  exp_t sb[$];

  // expectation for the state after the next rising edge
  task automatic push(input string r, input int s, input logic [7:0] v);
    exp_t e;
    e.req = r; e.sel = s; e.val = v;
    sb.push_back(e);
  endtask

  initial forever begin
    @(posedge clk);
    #1;
    while (sb.size() > 0) begin
      exp_t e;
      logic [7:0] act;
      e = sb.pop_front();
      case (e.sel)
        0:       act = {7'b0, irq_n};
        1:       act = f_bus;
        2:       act = f_card;
        default: act = f_misc;
      endcase
      nchk++;
      if (act !== e.val) begin
        nerr++;
        $display("FAIL %s sel=%0d actual=%h expected=%h", e.req, e.sel, act, e.val);
      end
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic write_reg(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic clear_irq();
    clr_n = 1'b0; tick(); clr_n = 1'b1;
  endtask

  task automatic hold_test(input logic [7:0] h, input int n, input string r);
    pwr_on = 1'b0; uv = '0;
    write_reg(3'd2, h);
    pwr_on = 1'b1; uv = 4'b0100;
    repeat (n) tick();
    push(r, 0, 8'h01);
    push("R11", 1, 8'h00);
    tick();
    push(r, 0, 8'h00);
    push("R7", 1, 8'h20);
    tick();
    pwr_on = 1'b0; uv = '0;
    clear_irq();
    write_reg(3'd4, 8'h00);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    push("R1", 0, 8'h01); push("R1", 1, 8'h00); push("R1", 2, 8'h00); push("R1", 3, 8'h00);
    tick();

    // default 1600 ms holdoff = 8 units
    pwr_on = 1'b1; uv = 4'b0001;
    repeat (8 * UNIT) tick();
    push("R1_R11", 0, 8'h01); push("R11", 1, 8'h00);
    tick();
    push("R3", 0, 8'h00); push("R7", 1, 8'h80);
    tick();
    uv = '0;
    push("R3", 0, 8'h00);
    tick();
    push("R3", 0, 8'h00);
    tick();

    // clear beats active source, then re-fire
    clr_n = 1'b0; uv = 4'b0001;
    push("R4", 0, 8'h01);
    tick();
    clr_n = 1'b1;
    push("R4", 0, 8'h00);
    tick();
    uv = '0; clr_n = 1'b0;
    push("R4", 0, 8'h01);
    tick();
    clr_n = 1'b1;
    push("R4", 0, 8'h01);
    tick();

    // record wins over simultaneous zero write
    uv = 4'b0001;
    push("R10", 1, 8'h80);
    write_reg(3'd4, 8'h00);
    uv = '0;
    clear_irq();

    // write ones: no effect; zero clears
    push("R9", 1, 8'h80);
    write_reg(3'd4, 8'hFF);
    push("R9", 1, 8'h00);
    write_reg(3'd4, 8'h7F);

    // masking of supplies 1/2; raw monitors recorded
    write_reg(3'd0, 8'h00);
    ov = 4'b0001;
    push("R2", 0, 8'h01); push("R2", 1, 8'h00);
    tick();
    cuv2 = 4'b0100; trk = 4'b1000;
    push("R2", 0, 8'h00); push("R7", 1, 8'h08); push("R7", 2, 8'h02); push("R7", 3, 8'h10);
    tick();
    ov = '0; cuv2 = '0; trk = '0;
    clear_irq();
    write_reg(3'd4, 8'h00); write_reg(3'd5, 8'h00); write_reg(3'd6, 8'h00);
    write_reg(3'd0, 8'hFF);

    // supply 3 card UV2 enable is bit 4 of byte 1
    write_reg(3'd1, 8'hEF);
    cuv2 = 4'b0100;
    push("R2", 0, 8'h01); push("R2", 2, 8'h00);
    tick();
    cuv2 = '0;
    write_reg(3'd1, 8'hFF);

    // over-current enables in holdoff byte
    write_reg(3'd2, 8'h77);
    oc = 4'b0001;
    push("R2", 0, 8'h01); push("R2", 3, 8'h00);
    tick();
    oc = 4'b0011;
    push("R2", 0, 8'h00); push("R7", 3, 8'h0C);
    tick();
    oc = '0;
    clear_irq();
    write_reg(3'd6, 8'h00);

    // power-down: nothing raised or recorded
    pwr_on = 1'b0;
    tick();
    uv = 4'b1000;
    push("R8", 0, 8'h01); push("R8", 1, 8'h00);
    tick();
    push("R8", 0, 8'h01); push("R8", 1, 8'h00);
    tick();
    uv = '0;

    hold_test(8'h4F, UNIT,     "R5");
    hold_test(8'h5F, 2 * UNIT, "R5");
    hold_test(8'h6F, 4 * UNIT, "R5");
    hold_test(8'h7F, 8 * UNIT, "R5");
    hold_test(8'h0F, 0,        "R6");
    hold_test(8'h3F, 0,        "R6");

    tick(); tick();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule